// File: doc/BRIEF.md
# Trigger Gate with Dead-Time and Busy Merging

This block decides, on every bunch-crossing clock, whether incoming trigger pulses may pass on to the distribution outputs. Four trigger channels arrive as single-cycle pulses on one vector. Bit 0 is the main accept, and bits 1 to 3 are three test triggers. A trigger passes only when nothing holds the gate shut. Several busy sources, a pattern-generator mask and an inhibit-window signal can each shut it. Every trigger that passes is reshaped into an output pulse of one or two clock periods.

In local mode, every trigger that passes opens a dead-time window. The length of this window is programmable from 0 to 8 clocks. The window is ORed into the internal busy, together with the external busy-module input, a busy from local logic, a software busy bit and the busy returned from downstream chained units. In global mode no dead time is generated. The upstream busy output then carries the external busy-module input unchanged, combinationally.

Configuration uses a single write-enabled port that loads the dead-time length, the pulse width and the software busy together. Triggers are plain pulses with no back-pressure, so the block has no valid/ready handshake. All pins are plain control and status.

Top module: `trig_gate_top`

## Requirements
- R1: With `mode_local`=0, `busy_up` equals `busy_ext` in the same cycle, and no dead-time window is ever opened.
- R2: With `mode_local`=1 and a programmed length L of 1 to 8, a trigger accepted in cycle t blocks all four trigger channels in cycles t+1 through t+L. A trigger in cycle t+L+1 may pass.
- R3: A programmed length of 0 disables dead-time generation. A programmed length above 8 behaves as 8.
- R4: The internal busy is the OR of `busy_ext`, `busy_loc`, the software busy bit, `busy_dn` and the active dead-time window. Any of these being high in a cycle blocks every trigger presented in that same cycle.
- R5: A trigger presented while `pg_mask` or `inhibit` is high is blocked.
- R6: A trigger accepted in cycle t drives its `trig_out` bit high in cycle t+1. With the wide setting (`cfg_wide`=1) that bit also stays high in cycle t+2.
- R7: `busy_mon` equals the internal busy in the same cycle. In local mode `busy_up` also equals the internal busy.
- R8: `status_busy` shows the internal busy value from the previous cycle.
- R9: After reset, `trig_out` and `status_busy` are 0, and the configuration is length 0, narrow pulses and software busy off.
- R10: Each `trig_in` bit maps only to the same `trig_out` bit: bit 0 is the main accept and bits 1 to 3 are the test triggers. `cfg_we`=1 loads `cfg_dead_len`, `cfg_wide` and `cfg_sw_busy` at the clock edge, and the new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_local | input | 1 | 1 = local mode, 0 = global mode |
| trig_in | input | 4 | Trigger pulses; bit 0 = main accept, bits 1 to 3 = test triggers |
| busy_ext | input | 1 | Busy from the external busy module |
| busy_loc | input | 1 | Busy from local logic |
| busy_dn | input | 1 | Busy returned from downstream chained units |
| pg_mask | input | 1 | Pattern-generator trigger mask |
| inhibit | input | 1 | Inhibit-window signal |
| cfg_we | input | 1 | Configuration write enable |
| cfg_dead_len | input | 4 | Dead-time length in clocks (above 8 is treated as 8) |
| cfg_wide | input | 1 | 1 = two-clock output pulse, 0 = one-clock output pulse |
| cfg_sw_busy | input | 1 | Software busy bit |
| trig_out | output | 4 | Shaped trigger pulses that passed the gate |
| busy_up | output | 1 | Busy toward the upstream link |
| busy_mon | output | 1 | Combined busy for monitoring or local logic |
| status_busy | output | 1 | Registered busy state for readback |

## Verification
The assertions check the following on every cycle:
- the transparent busy path in global mode;
- the match between the monitoring busy and the upstream busy in local mode;
- that no output pulse ever starts without an unblocked trigger in the cycle before;
- that a busy, mask or inhibit cycle yields no output when narrow pulses are selected;
- that the dead-time window is already raised in the cycle after an accepted trigger.

Other properties can only be shown by the bench's scenarios:
- the exact window length and the clamp at 8;
- the disable value 0;
- the two-clock pulse stretch;
- per-channel independence;
- the one-cycle lag of the status bit.

The bench scenarios also cover configuration taking effect at the right edge, and dead-time clearing on a switch to global mode.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int NTRIG   = 4;   // trigger channels
  localparam int DLEN_W  = 4;   // width of programmed dead-time length
  localparam int DMAX    = 8;   // longest dead-time window in clocks
  localparam int CNT_W   = $clog2(DMAX + 1);
  localparam int NBUSY   = 5;   // busy sources merged
endpackage

// File: rtl/tg_busy_merge.sv
module tg_busy_merge #(
  parameter int NSRC = 5
) (
  input  logic [NSRC-1:0] src,
  output logic            busy
);
  assign busy = |src;
endmodule

// File: rtl/tg_dead_timer.sv
module tg_dead_timer
  import tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_local,
  input  logic              start,
  input  logic [DLEN_W-1:0] len,
  output logic              active
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_eff;

  // lengths above the maximum saturate
  assign len_eff = (32'(len) > DMAX) ? CNT_W'(DMAX) : CNT_W'(len);

  always_ff @(posedge clk) begin
    if (!rst_n || !mode_local) begin
      cnt_q <= '0;
    end else if (start && len_eff != '0) begin
      cnt_q <= len_eff;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/tg_pulse_shaper.sv
module tg_pulse_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic wide,
  output logic pulse
);
  logic fire_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      fire_q <= fire;
      pulse  <= fire | (wide & fire_q);
    end
  end
endmodule

// File: rtl/trig_gate_top.sv
module trig_gate_top
  import tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_local,
  input  logic [NTRIG-1:0]  trig_in,
  input  logic              busy_ext,
  input  logic              busy_loc,
  input  logic              busy_dn,
  input  logic              pg_mask,
  input  logic              inhibit,
  input  logic              cfg_we,
  input  logic [DLEN_W-1:0] cfg_dead_len,
  input  logic              cfg_wide,
  input  logic              cfg_sw_busy,
  output logic [NTRIG-1:0]  trig_out,
  output logic              busy_up,
  output logic              busy_mon,
  output logic              status_busy
);
  logic [DLEN_W-1:0] dlen_q;
  logic              wide_q;
  logic              sw_busy_q;
  logic              dead_active;
  logic              busy_int;
  logic              gate_shut;
  logic [NTRIG-1:0]  accept;

  // configuration register (R10, R9)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlen_q    <= '0;
      wide_q    <= 1'b0;
      sw_busy_q <= 1'b0;
    end else if (cfg_we) begin
      dlen_q    <= cfg_dead_len;
      wide_q    <= cfg_wide;
      sw_busy_q <= cfg_sw_busy;
    end
  end

  // busy sources (R4)
  tg_busy_merge #(.NSRC(NBUSY)) u_merge (
    .src  ({busy_ext, busy_loc, sw_busy_q, busy_dn, dead_active}),
    .busy (busy_int)
  );

  // gate (R4, R5)
  assign gate_shut = busy_int | pg_mask | inhibit;
  assign accept    = gate_shut ? '0 : trig_in;

  // dead time (R1, R2, R3)
  tg_dead_timer u_dead (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_local (mode_local),
    .start      (|accept),
    .len        (dlen_q),
    .active     (dead_active)
  );

  // per-channel pulse shaping (R6, R10)
  for (genvar g = 0; g < NTRIG; g++) begin : g_shape
    tg_pulse_shaper u_shape (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (accept[g]),
      .wide  (wide_q),
      .pulse (trig_out[g])
    );
  end

  // busy outputs (R1, R7, R8)
  assign busy_up  = mode_local ? busy_int : busy_ext;
  assign busy_mon = busy_int;

  always_ff @(posedge clk) begin
    if (!rst_n) status_busy <= 1'b0;
    else        status_busy <= busy_int;
  end
endmodule

// File: rtl/tg_checker.sv
module tg_checker
  import tg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_local,
  input logic [NTRIG-1:0]  trig_in,
  input logic              busy_ext,
  input logic              pg_mask,
  input logic              inhibit,
  input logic [NTRIG-1:0]  trig_out,
  input logic              busy_up,
  input logic              busy_mon,
  input logic              wide,
  input logic [DLEN_W-1:0] dlen
);
  a_r1_global_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_local |-> busy_up == busy_ext);

  a_r7_local_busy_up: assert property (@(posedge clk) disable iff (!rst_n)
    mode_local |-> busy_up == busy_mon);

  a_r4_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_mon && !wide) |=> trig_out == '0);

  a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ((pg_mask || inhibit) && !wide) |=> trig_out == '0);

  a_r2_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_local) && $past(dlen) != '0 && $rose(|trig_out)) |-> busy_mon);

  for (genvar g = 0; g < NTRIG; g++) begin : g_org
    a_r6_pulse_origin: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig_out[g]) |-> $past(trig_in[g] && !busy_mon && !pg_mask && !inhibit));
  end
endmodule

bind trig_gate_top tg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_local (mode_local),
  .trig_in    (trig_in),
  .busy_ext   (busy_ext),
  .pg_mask    (pg_mask),
  .inhibit    (inhibit),
  .trig_out   (trig_out),
  .busy_up    (busy_up),
  .busy_mon   (busy_mon),
  .wide       (wide_q),
  .dlen       (dlen_q)
);

// File: tb/tb_trig_gate_top.sv
module tb_trig_gate_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_local = 1'b0;
  logic [3:0] trig_in = '0;
  logic       busy_ext = 0, busy_loc = 0, busy_dn = 0, pg_mask = 0, inhibit = 0;
  logic       cfg_we = 0, cfg_wide = 0, cfg_sw_busy = 0;
  logic [3:0] cfg_dead_len = '0;
  logic [3:0] trig_out;
  logic       busy_up, busy_mon, status_busy;

  int n_run = 0;
  int n_fail = 0;

  typedef struct { logic [3:0] out; logic stat; string tag; } exp_t;
  exp_t q[$];

  // reference state
  int         m_dt = 0;
  int         m_len = 0;
  logic       m_wide = 0;
  logic       m_sw = 0;
  logic [3:0] m_prev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_gate_top dut (
    .clk(clk), .rst_n(rst_n), .mode_local(mode_local), .trig_in(trig_in),
    .busy_ext(busy_ext), .busy_loc(busy_loc), .busy_dn(busy_dn),
    .pg_mask(pg_mask), .inhibit(inhibit), .cfg_we(cfg_we),
    .cfg_dead_len(cfg_dead_len), .cfg_wide(cfg_wide), .cfg_sw_busy(cfg_sw_busy),
    .trig_out(trig_out), .busy_up(busy_up), .busy_mon(busy_mon),
    .status_busy(status_busy)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // monitor: pops expected results mid-cycle after each edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "trig_out", int'(trig_out), int'(e.out));
      check("R8", "status_busy", int'(status_busy), int'(e.stat));
    end
  end

  // driver: one cycle of stimulus, called at a falling edge
  task automatic step(input logic [3:0] t, input logic e, input logic l,
                      input logic d, input logic p, input logic i, input string tag);
    logic       busy;
    logic [3:0] acc;
    exp_t       x;
    trig_in = t; busy_ext = e; busy_loc = l; busy_dn = d; pg_mask = p; inhibit = i;
    #1;
    busy = e | l | d | m_sw | (m_dt != 0);
    check(mode_local ? "R7" : "R1", "busy_up", int'(busy_up),
          int'(mode_local ? busy : e));
    check("R7", "busy_mon", int'(busy_mon), int'(busy));
    acc = (busy | p | i) ? 4'b0 : t;
    x.out  = acc | (m_wide ? m_prev : 4'b0);
    x.stat = busy;
    x.tag  = tag;
    q.push_back(x);
    m_prev = acc;
    if (!mode_local)            m_dt = 0;
    else if (|acc && m_len > 0) m_dt = m_len;
    else if (m_dt > 0)          m_dt = m_dt - 1;
    if (cfg_we) begin
      m_len  = (int'(cfg_dead_len) > 8) ? 8 : int'(cfg_dead_len);
      m_wide = cfg_wide;
      m_sw   = cfg_sw_busy;
    end
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(4'b0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic cfg(input logic [3:0] len, input logic w, input logic sw);
    cfg_we = 1; cfg_dead_len = len; cfg_wide = w; cfg_sw_busy = sw;
    step(4'b0, 0, 0, 0, 0, 0, "R10");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R9: reset state
    check("R9", "trig_out", int'(trig_out), 0);
    check("R9", "status_busy", int'(status_busy), 0);
    @(negedge clk);

    // R9: default config = length 0 and narrow, so back-to-back triggers pass
    mode_local = 1;
    for (int k = 0; k < 3; k++) step(4'b0001, 0, 0, 0, 0, 0, "R9");
    idle(2, "R9");

    // R1: global passthrough; local busy does not reach busy_up
    mode_local = 0;
    step(4'b0, 1, 0, 0, 0, 0, "R1");
    step(4'b0, 0, 1, 0, 0, 0, "R1");
    step(4'b0, 0, 0, 1, 0, 0, "R1");
    cfg(4'd3, 0, 0);
    // R1: no dead time in global mode
    for (int k = 0; k < 4; k++) step(4'b0001, 0, 0, 0, 0, 0, "R1");
    idle(2, "R1");

    // R2: local window of 3
    mode_local = 1;
    idle(1, "R2");
    for (int k = 0; k < 6; k++) step(4'b0001, 0, 0, 0, 0, 0, "R2");
    idle(4, "R2");
    // R10: test-trigger channels independent
    step(4'b0010, 0, 0, 0, 0, 0, "R10"); idle(3, "R10");
    step(4'b0100, 0, 0, 0, 0, 0, "R10"); step(4'b1000, 0, 0, 0, 0, 0, "R10");
    idle(3, "R10");
    step(4'b1010, 0, 0, 0, 0, 0, "R10"); idle(4, "R10");

    // R3: clamp above 8, then disable at 0
    cfg(4'd15, 0, 0);
    for (int k = 0; k < 11; k++) step(4'b0100, 0, 0, 0, 0, 0, "R3");
    idle(9, "R3");
    cfg(4'd0, 0, 0);
    for (int k = 0; k < 4; k++) step(4'b1000, 0, 0, 0, 0, 0, "R3");
    idle(1, "R3");

    // R4: each busy source blocks in the same cycle
    step(4'b0001, 1, 0, 0, 0, 0, "R4");
    step(4'b0001, 0, 1, 0, 0, 0, "R4");
    step(4'b0001, 0, 0, 1, 0, 0, "R4");
    cfg(4'd0, 0, 1);
    step(4'b0011, 0, 0, 0, 0, 0, "R4");
    cfg(4'd0, 0, 0);
    step(4'b0011, 0, 0, 0, 0, 0, "R4");
    idle(1, "R4");

    // R5: mask and inhibit
    step(4'b1111, 0, 0, 0, 1, 0, "R5");
    step(4'b1111, 0, 0, 0, 0, 1, "R5");
    step(4'b1111, 0, 0, 0, 0, 0, "R5");
    idle(2, "R5");

    // R6: wide pulses, with and without dead time
    cfg(4'd0, 1, 0);
    step(4'b0001, 0, 0, 0, 0, 0, "R6"); idle(3, "R6");
    step(4'b0110, 0, 0, 0, 0, 0, "R6"); step(4'b0110, 0, 0, 0, 0, 0, "R6");
    idle(3, "R6");
    cfg(4'd1, 1, 0);
    for (int k = 0; k < 5; k++) step(4'b0001, 0, 0, 0, 0, 0, "R6");
    idle(3, "R6");

    // R1: switching to global clears the window
    cfg(4'd8, 0, 0);
    step(4'b0001, 0, 0, 0, 0, 0, "R1");
    mode_local = 0;
    step(4'b0001, 0, 0, 0, 0, 0, "R1");
    step(4'b0001, 0, 0, 0, 0, 0, "R1");
    idle(3, "R1");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule